// File: doc/BRIEF.md
# Wear-Adaptive ECC Level Controller

This block decides, for every group of memory pages, how many bit errors the error-correcting code of that group must be able to repair. Pages share one memory space with their check bits, and every data page of a group is protected at the same strength. Wear is estimated from write traffic. Each time an encryption counter is bumped for a line write-back, the memory controller reports a write event tagged with the group that holds the line. The block keeps a saturating write tally per group. It steps the group's protection level up by one whenever the tally reaches the next entry of a programmable threshold table.

Every step produces a one-cycle notice that carries the group ID and the new level, so that an allocator can claim extra check-bit pages inside that group. The ECC datapath reads the level of any group through a registered query port. That port also returns the number of check bits the code needs for a 512-bit data word, which is ten bits per correctable error. The BCH encoder and decoder themselves are not part of the block.

Top module: `ecc_wear_level_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, `raise_pulse_o` is low and both query outputs read zero. After reset every group sits at level 1 (BASE_LEVEL) with a zero tally.
- R2: Each accepted write event adds one to the tally of the tagged group only. A tally stops at 2^TALLY_W-1 (1023 by default) and never wraps. With every threshold at 1023, a group therefore steps on its 1023rd write and on each later write until it reaches the top level.
- R3: A group steps up when its tally after the event is greater than or equal to table entry (level - BASE_LEVEL). Entry k occupies bits [k*TALLY_W +: TALLY_W] of `thr_table_i`.
- R4: One event raises a level by at most one step. If the table is flat or descending, the following events to that group each step it once.
- R5: No level exceeds MAX_LEVEL (6 by default). An event to a group already at MAX_LEVEL produces no pulse.
- R6: `raise_pulse_o` is high for exactly the cycle after the clock edge that accepted a stepping event. In that cycle `raise_gid_o` holds the group ID and `raise_level_o` holds the new level. No other cycle has the pulse high.
- R7: One cycle after a query of group g, `qry_level_o` holds the level of g and `qry_ecc_bits_o` holds 10 times that level. A write accepted at the same edge shows only in later queries.
- R8: A level never decreases, even when the threshold table is later reprogrammed to higher values.
- R9: Events for one group leave the tallies and levels of all other groups unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_valid_i | input | 1 | A write event is present this cycle |
| wr_gid_i | input | GID_W | Group that received the write |
| thr_table_i | input | NUM_STEPS*TALLY_W | Threshold table; entry k sits at [k*TALLY_W +: TALLY_W] |
| qry_gid_i | input | GID_W | Group whose level is requested |
| qry_level_o | output | LVL_W | Level of the queried group, one cycle later |
| qry_ecc_bits_o | output | BITS_W | Check bits required per 512-bit word (10 x level) |
| raise_pulse_o | output | 1 | One-cycle notice that a group's level stepped |
| raise_gid_o | output | GID_W | Group that stepped (valid with the pulse) |
| raise_level_o | output | LVL_W | New level of that group (valid with the pulse) |

## Verification
Two functions can land in the same cycle: a write event that steps a group's level, and a query of that same group. The bench provokes this collision by aiming the query at the group it is writing while the tally climbs through each threshold. A reference model then expects three things: the old level in the cycle after the edge, the pulse carrying the new level in that same cycle, and the new level one cycle later. Back-to-back stepping writes under a flat table put pulses on consecutive cycles, and each pulse's level is checked against the one before it.

// File: rtl/ecc_lvl_pkg.sv
// Package: shared constants, the step decision type and the check-bit cost
// helper for the wear-adaptive ECC level controller.
// Assumes: every correctable bit costs the same number of check bits.
package ecc_lvl_pkg;

    // Check bits spent per correctable error over one 512-bit data word.
    localparam int unsigned ECC_BITS_PER_LEVEL = 10;
    localparam int unsigned ECC_DATA_WORD_BITS = 512;

    // Outcome of evaluating one write event against the threshold table.
    typedef enum logic [1:0] {
        STEP_NONE   = 2'd0,
        STEP_RAISE  = 2'd1,
        STEP_CAPPED = 2'd2
    } step_e;

    // Check-bit cost of a protection level.
    function automatic int unsigned ecc_bits_for(input int unsigned level);
        return level * ECC_BITS_PER_LEVEL;
    endfunction

endpackage

// File: rtl/ecc_wear_tally.sv
// Module: per-group saturating write tallies.
// What it does: keeps one TALLY_W-bit counter per page group. On an event it
// bumps the tagged group's counter and exposes the post-event value.
// Assumes: hit_gid is below NUM_GROUPS whenever hit_valid is high.
module ecc_wear_tally #(
    parameter int NUM_GROUPS = 8,
    parameter int GID_W      = 3,
    parameter int TALLY_W    = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hit_valid,
    input  logic [GID_W-1:0]   hit_gid,
    output logic [TALLY_W-1:0] hit_tally_next
);

    localparam logic [TALLY_W-1:0] TALLY_MAX = {TALLY_W{1'b1}};

    logic [TALLY_W-1:0] tally_q [NUM_GROUPS];
    logic [TALLY_W-1:0] hit_tally_cur;

    // Select the tally of the group named by the event.
    assign hit_tally_cur = tally_q[hit_gid];

    // Saturating increment: a worn-out counter must never wrap to fresh.
    assign hit_tally_next = (hit_tally_cur == TALLY_MAX) ? hit_tally_cur
                                                         : hit_tally_cur + 1'b1;

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_tally
        // Hold or advance this group's tally.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tally_q[g] <= '0;
            end else if (hit_valid && hit_gid == GID_W'(g)) begin
                tally_q[g] <= hit_tally_next;
            end
        end
    end

endmodule

// File: rtl/ecc_level_step.sv
// Module: threshold comparison for one write event.
// What it does: picks the table entry that belongs to the current level and
// decides whether the post-event tally earns one more level.
// Assumes: cur_level lies in [BASE_LEVEL, MAX_LEVEL]; the table is meant to
// be ascending, though any order still yields one step per event.
module ecc_level_step
    import ecc_lvl_pkg::*;
#(
    parameter int TALLY_W    = 10,
    parameter int LVL_W      = 3,
    parameter int BASE_LEVEL = 1,
    parameter int MAX_LEVEL  = 6,
    parameter int NUM_STEPS  = MAX_LEVEL - BASE_LEVEL
) (
    input  logic [LVL_W-1:0]           cur_level,
    input  logic [TALLY_W-1:0]         tally_next,
    input  logic [NUM_STEPS*TALLY_W-1:0] thr_table,
    output step_e                      step,
    output logic [LVL_W-1:0]           next_level
);

    localparam logic [LVL_W-1:0] LVL_TOP = LVL_W'(MAX_LEVEL);

    logic [TALLY_W-1:0] thr_sel;

    // Pick the threshold entry indexed by (level - BASE_LEVEL).
    always_comb begin
        thr_sel = {TALLY_W{1'b1}};
        for (int k = 0; k < NUM_STEPS; k++) begin
            if (cur_level == LVL_W'(BASE_LEVEL + k)) begin
                thr_sel = thr_table[k*TALLY_W +: TALLY_W];
            end
        end
    end

    // Decide the step: capped at the top, else raise when the tally has reached the entry.
    always_comb begin
        if (cur_level >= LVL_TOP) begin
            step = STEP_CAPPED;
        end else if (tally_next >= thr_sel) begin
            step = STEP_RAISE;
        end else begin
            step = STEP_NONE;
        end
    end

    // Candidate level after one step.
    assign next_level = cur_level + 1'b1;

endmodule

// File: rtl/ecc_level_bank.sv
// Module: per-group protection levels and the level-change notice.
// What it does: stores one level per group. It applies a raise from the step
// logic and registers a one-cycle pulse that carries the group and new level.
// Assumes: levels only climb; no path lowers a level outside reset.
module ecc_level_bank
    import ecc_lvl_pkg::*;
#(
    parameter int NUM_GROUPS = 8,
    parameter int GID_W      = 3,
    parameter int LVL_W      = 3,
    parameter int BASE_LEVEL = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit_valid,
    input  logic [GID_W-1:0] hit_gid,
    input  step_e            step,
    input  logic [LVL_W-1:0] new_level,
    input  logic [GID_W-1:0] qry_gid,
    output logic [LVL_W-1:0] hit_level,
    output logic [LVL_W-1:0] qry_level,
    output logic             raise_pulse,
    output logic [GID_W-1:0] raise_gid,
    output logic [LVL_W-1:0] raise_level
);

    logic [LVL_W-1:0] level_q [NUM_GROUPS];
    logic             do_raise;

    // Level of the group under write, fed to the step logic.
    assign hit_level = level_q[hit_gid];

    // Level of the group under query, before this edge's update.
    assign qry_level = level_q[qry_gid];

    // A raise is committed only for a valid event judged RAISE.
    assign do_raise = hit_valid && (step == STEP_RAISE);

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_level
        // Hold or step this group's level.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                level_q[g] <= LVL_W'(BASE_LEVEL);
            end else if (do_raise && hit_gid == GID_W'(g)) begin
                level_q[g] <= new_level;
            end
        end
    end

    // One-cycle change notice for the ECC page allocator.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raise_pulse <= 1'b0;
            raise_gid   <= '0;
            raise_level <= '0;
        end else begin
            raise_pulse <= do_raise;
            if (do_raise) begin
                raise_gid   <= hit_gid;
                raise_level <= new_level;
            end
        end
    end

endmodule

// File: rtl/ecc_query_port.sv
// Module: registered level lookup for the ECC datapath.
// What it does: latches the queried level and its check-bit cost each cycle.
// Assumes: the level handed in is the value before this edge's update.
module ecc_query_port
    import ecc_lvl_pkg::*;
#(
    parameter int LVL_W  = 3,
    parameter int BITS_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LVL_W-1:0]  lvl_in,
    output logic [LVL_W-1:0]  qry_level,
    output logic [BITS_W-1:0] qry_bits
);

    logic [BITS_W-1:0] bits_calc;

    // Check-bit cost of the looked-up level.
    assign bits_calc = BITS_W'(ecc_bits_for(int'(lvl_in)));

    // Register level and cost together for a one-cycle lookup.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            qry_level <= '0;
            qry_bits  <= '0;
        end else begin
            qry_level <= lvl_in;
            qry_bits  <= bits_calc;
        end
    end

endmodule

// File: rtl/ecc_wear_level_ctrl.sv
// Module: top of the wear-adaptive ECC level controller.
// What it does: counts writes per page group, steps each group's protection
// level through a programmable threshold table, notifies the allocator of
// every step, and answers level queries from the ECC datapath.
// Assumes: group IDs are below NUM_GROUPS; the table is stable while events
// that depend on it arrive.
module ecc_wear_level_ctrl
    import ecc_lvl_pkg::*;
#(
    parameter int NUM_GROUPS = 8,
    parameter int GID_W      = $clog2(NUM_GROUPS),
    parameter int TALLY_W    = 10,
    parameter int BASE_LEVEL = 1,
    parameter int MAX_LEVEL  = 6,
    parameter int NUM_STEPS  = MAX_LEVEL - BASE_LEVEL,
    parameter int LVL_W      = $clog2(MAX_LEVEL + 1),
    parameter int BITS_W     = $clog2(MAX_LEVEL * ECC_BITS_PER_LEVEL + 1)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_valid_i,
    input  logic [GID_W-1:0]             wr_gid_i,
    input  logic [NUM_STEPS*TALLY_W-1:0] thr_table_i,
    input  logic [GID_W-1:0]             qry_gid_i,
    output logic [LVL_W-1:0]             qry_level_o,
    output logic [BITS_W-1:0]            qry_ecc_bits_o,
    output logic                         raise_pulse_o,
    output logic [GID_W-1:0]             raise_gid_o,
    output logic [LVL_W-1:0]             raise_level_o
);

    logic [TALLY_W-1:0] tally_next;
    logic [LVL_W-1:0]   hit_level;
    logic [LVL_W-1:0]   next_level;
    logic [LVL_W-1:0]   qry_level_raw;
    step_e              step;

    // Per-group write tallies.
    ecc_wear_tally #(
        .NUM_GROUPS (NUM_GROUPS),
        .GID_W      (GID_W),
        .TALLY_W    (TALLY_W)
    ) tally_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .hit_valid      (wr_valid_i),
        .hit_gid        (wr_gid_i),
        .hit_tally_next (tally_next)
    );

    // Threshold comparison for the current event.
    ecc_level_step #(
        .TALLY_W    (TALLY_W),
        .LVL_W      (LVL_W),
        .BASE_LEVEL (BASE_LEVEL),
        .MAX_LEVEL  (MAX_LEVEL),
        .NUM_STEPS  (NUM_STEPS)
    ) step_i (
        .cur_level  (hit_level),
        .tally_next (tally_next),
        .thr_table  (thr_table_i),
        .step       (step),
        .next_level (next_level)
    );

    // Level storage and change notice.
    ecc_level_bank #(
        .NUM_GROUPS (NUM_GROUPS),
        .GID_W      (GID_W),
        .LVL_W      (LVL_W),
        .BASE_LEVEL (BASE_LEVEL)
    ) bank_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .hit_valid   (wr_valid_i),
        .hit_gid     (wr_gid_i),
        .step        (step),
        .new_level   (next_level),
        .qry_gid     (qry_gid_i),
        .hit_level   (hit_level),
        .qry_level   (qry_level_raw),
        .raise_pulse (raise_pulse_o),
        .raise_gid   (raise_gid_o),
        .raise_level (raise_level_o)
    );

    // Registered lookup toward the ECC datapath.
    ecc_query_port #(
        .LVL_W  (LVL_W),
        .BITS_W (BITS_W)
    ) query_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .lvl_in    (qry_level_raw),
        .qry_level (qry_level_o),
        .qry_bits  (qry_ecc_bits_o)
    );

endmodule

// File: rtl/ecc_wear_level_chk.sv
// Module: property checker bound to the level controller.
// What it does: watches the ports for pulse origin, level ordering, cap and
// query consistency.
// Assumes: bound through the statement at the end of this file.
module ecc_wear_level_chk #(
    parameter int GID_W      = 3,
    parameter int LVL_W      = 3,
    parameter int BITS_W     = 6,
    parameter int BASE_LEVEL = 1,
    parameter int MAX_LEVEL  = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_valid_i,
    input logic [GID_W-1:0]  wr_gid_i,
    input logic [GID_W-1:0]  qry_gid_i,
    input logic [LVL_W-1:0]  qry_level_o,
    input logic [BITS_W-1:0] qry_ecc_bits_o,
    input logic              raise_pulse_o,
    input logic [GID_W-1:0]  raise_gid_o,
    input logic [LVL_W-1:0]  raise_level_o
);

    // R1
    no_pulse_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> !raise_pulse_o);

    // R6
    pulse_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        raise_pulse_o |-> ($past(wr_valid_i) && raise_gid_o == $past(wr_gid_i)));

    // R5
    level_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        raise_pulse_o |-> (raise_level_o <= LVL_W'(MAX_LEVEL)
                           && raise_level_o > LVL_W'(BASE_LEVEL)));

    // R4
    single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (raise_pulse_o && $past(raise_pulse_o) && raise_gid_o == $past(raise_gid_o))
            |-> raise_level_o == $past(raise_level_o) + 1'b1);

    // R8
    no_decrease_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(qry_gid_i) == $past(qry_gid_i, 2)) |-> qry_level_o >= $past(qry_level_o));

    // R7
    bits_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(qry_ecc_bits_o) == int'(qry_level_o) * 10);

endmodule

bind ecc_wear_level_ctrl ecc_wear_level_chk #(
    .GID_W      (GID_W),
    .LVL_W      (LVL_W),
    .BITS_W     (BITS_W),
    .BASE_LEVEL (BASE_LEVEL),
    .MAX_LEVEL  (MAX_LEVEL)
) chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .wr_valid_i     (wr_valid_i),
    .wr_gid_i       (wr_gid_i),
    .qry_gid_i      (qry_gid_i),
    .qry_level_o    (qry_level_o),
    .qry_ecc_bits_o (qry_ecc_bits_o),
    .raise_pulse_o  (raise_pulse_o),
    .raise_gid_o    (raise_gid_o),
    .raise_level_o  (raise_level_o)
);

// File: tb/ecc_wear_level_ctrl_tb_top.sv
`timescale 1ns/1ps
// Bench: behavioural per-group model compared with the design on every cycle.
module ecc_wear_level_ctrl_tb_top;

    localparam int NG    = 8;
    localparam int GW    = 3;
    localparam int TW    = 10;
    localparam int NS    = 5;
    localparam int LW    = 3;
    localparam int BW    = 6;
    localparam int TMAX  = 1023;
    localparam int LTOP  = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_valid = 1'b0;
    logic [GW-1:0] wr_gid = '0;
    logic [NS*TW-1:0] thr_flat = '0;
    logic [GW-1:0] qry_gid = '0;
    logic [LW-1:0] qry_level;
    logic [BW-1:0] qry_bits;
    logic          raise_pulse;
    logic [GW-1:0] raise_gid;
    logic [LW-1:0] raise_level;

    int n_chk  = 0;
    int n_fail = 0;
    string cur_tag = "R1";
    bit started = 1'b0;

    // Model state and expected outputs.
    int m_tally [NG];
    int m_level [NG];
    int e_pulse = 0, e_gid = 0, e_lvl = 0, e_ql = 0, e_qb = 0;

    always #2.5 clk = ~clk;

    ecc_wear_level_ctrl dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .wr_valid_i     (wr_valid),
        .wr_gid_i       (wr_gid),
        .thr_table_i    (thr_flat),
        .qry_gid_i      (qry_gid),
        .qry_level_o    (qry_level),
        .qry_ecc_bits_o (qry_bits),
        .raise_pulse_o  (raise_pulse),
        .raise_gid_o    (raise_gid),
        .raise_level_o  (raise_level)
    );

    // Reference model: advances at each rising edge from the stable inputs.
    always @(posedge clk) begin
        started <= 1'b1;
        if (!rst_n) begin
            for (int g = 0; g < NG; g++) begin
                m_tally[g] = 0;
                m_level[g] = 1;
            end
            e_pulse = 0; e_gid = 0; e_lvl = 0; e_ql = 0; e_qb = 0;
        end else begin
            int t;
            int g;
            e_ql = m_level[qry_gid];
            e_qb = 10 * e_ql;
            e_pulse = 0;
            if (wr_valid) begin
                g = int'(wr_gid);
                t = m_tally[g];
                if (t < TMAX) t = t + 1;
                m_tally[g] = t;
                if (m_level[g] < LTOP && t >= int'(thr_flat[(m_level[g]-1)*TW +: TW])) begin
                    m_level[g] = m_level[g] + 1;
                    e_pulse = 1;
                    e_gid = g;
                    e_lvl = m_level[g];
                end
            end
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s (%s) %s: actual %0d expected %0d at %0t", req, cur_tag, what, act, exp, $time);
        end
    endtask

    // Compare every cycle, away from the rising edge.
    always @(negedge clk) begin
        if (started) begin
            check("R6", "raise_pulse_o", int'(raise_pulse), e_pulse);
            if (e_pulse != 0) begin
                check("R6", "raise_gid_o", int'(raise_gid), e_gid);
                check("R6", "raise_level_o", int'(raise_level), e_lvl);
            end
            check("R7", "qry_level_o", int'(qry_level), e_ql);
            check("R7", "qry_ecc_bits_o", int'(qry_bits), e_qb);
        end
    end

    task automatic set_thr(input int a, input int b, input int c, input int d, input int e);
        thr_flat = {TW'(e), TW'(d), TW'(c), TW'(b), TW'(a)};
    endtask

    task automatic cyc(input bit v, input int g, input int q);
        @(negedge clk);
        wr_valid = v;
        wr_gid   = GW'(g);
        qry_gid  = GW'(q);
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired: actual hung expected done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        // R1: reset holds outputs at zero, then every group reads level 1.
        cur_tag = "R1";
        set_thr(4, 8, 12, 16, 20);
        repeat (3) @(negedge clk);
        check("R1", "pulse in reset", int'(raise_pulse), 0);
        check("R1", "qry_level in reset", int'(qry_level), 0);
        rst_n = 1'b1;
        for (int q = 0; q < NG; q++) cyc(1'b0, 0, q);
        cyc(1'b0, 0, 0);

        // R3 with R7 collision: write group 2 while querying it.
        cur_tag = "R3";
        for (int i = 0; i < 20; i++) cyc(1'b1, 2, 2);

        // R5: further writes at the top level give no pulse.
        cur_tag = "R5";
        for (int i = 0; i < 6; i++) cyc(1'b1, 2, 2);
        cyc(1'b0, 0, 2);

        // R9: interleaved groups with idle gaps, others queried.
        cur_tag = "R9";
        set_thr(3, 5, 9, 30, 40);
        for (int i = 0; i < 12; i++) begin
            cyc(1'b1, 0, i % NG);
            cyc(1'b1, 1, 2);
            cyc(1'b0, 0, 3);
        end
        for (int q = 0; q < NG; q++) cyc(1'b0, 0, q);

        // R4: flat table steps once per write on consecutive writes.
        cur_tag = "R4";
        set_thr(2, 2, 2, 2, 2);
        for (int i = 0; i < 8; i++) cyc(1'b1, 5, 5);
        cyc(1'b0, 0, 5);

        // R8: raise thresholds after levels were reached; levels hold.
        cur_tag = "R8";
        set_thr(TMAX, TMAX, TMAX, TMAX, TMAX);
        for (int i = 0; i < 10; i++) cyc(1'b1, 0, 0);
        for (int q = 0; q < NG; q++) cyc(1'b0, 0, q);

        // R2: saturated tally keeps meeting the top threshold.
        cur_tag = "R2";
        for (int i = 0; i < 1032; i++) cyc(1'b1, 7, 7);
        for (int q = 0; q < NG; q++) cyc(1'b0, 0, q);
        cyc(1'b0, 0, 0);
        @(negedge clk);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule